// File: doc/BRIEF.md
# Up-Counting Compare Timer Pair

This block holds a set of independent interval timers, two by default, each driven by the system clock. Every timer has three word registers: a control word, a compare value and a counter. Software may load the counter with a start value, set the compare value, and then enable the timer. While enabled, the counter climbs by one per clock. When it equals the compare value, the timer raises its own interrupt line for one clock.

After that match the timer follows one of two modes. In one-shot mode it stops and clears its own enable bit, and the counter keeps the compare value. In auto-restart mode it wraps to zero and runs on, giving a period of compare plus one clocks.

Each timer has its own small register port: a write strobe, a two-bit field select, write data and combinational read data. This lets a bus decoder outside the block map the timers wherever it likes.

Top module: `cmp_timer_pair`

## Requirements
- R1: In the control word, bit 0 is enable and bit 1 is auto-restart. All other control bits read back as zero whatever was written.
- R2: While enabled and not matching, the counter rises by exactly one per clock. Reading the counter returns its current value.
- R3: Field select encoding is 0 = control, 1 = compare, 2 = counter. Select 3 reads zero, and a write with select 3 changes no register.
- R4: When an enabled timer's counter equals its compare value at a clock edge, its interrupt output is high for the following clock cycle only.
- R5: On a match with auto-restart clear, the enable bit reads back as zero afterwards, the counter keeps the compare value and no further interrupt follows.
- R6: On a match with auto-restart set, the counter becomes zero on that edge and counting goes on, so interrupts repeat every compare+1 clocks.
- R7: Writing a control word with enable clear stops the timer at once, and the counter then holds its value.
- R8: After reset every register of every timer reads zero, all timers are stopped and all interrupt outputs are low.
- R9: A counter write takes effect on the edge where it occurs and overrides the increment of that same edge.
- R10: Timers are independent: activity on one timer's port never changes another timer's registers or interrupt.
- R11: Enabling a timer starts counting from the value the counter holds. If that value already equals compare, the interrupt follows after one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_wr | input | NUM_TIMERS | Write strobe, one per timer |
| tmr_sel | input | NUM_TIMERS x 2 | Field select per timer (0 control, 1 compare, 2 counter) |
| tmr_wdata | input | NUM_TIMERS x DATA_W | Write data per timer |
| tmr_rdata | output | NUM_TIMERS x DATA_W | Read data of the selected field per timer |
| tmr_irq | output | NUM_TIMERS | One-clock interrupt pulse per timer |

## Verification
The timers are run in one-shot mode from a preload of zero and from a middle preload, and in auto-restart mode over several periods. The first pair separates correct match timing from off-by-one errors in the start value. The auto-restart run separates a wrap to zero from a wrap to one, or a missing wrap, through the spacing between pulses. Further patterns cover a counter rewrite while running, which shows whether the write beats the increment; a start with counter equal to compare; a stop in mid-run; and a write with select 3. A scoreboard predicts the clock cycle of every interrupt pulse and rejects missing, late and extra pulses on each line.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

   typedef enum logic [1:0] {
      FLD_CTRL = 2'd0,
      FLD_CMP  = 2'd1,
      FLD_CNT  = 2'd2,
      FLD_NONE = 2'd3
   } fld_e;

   typedef struct packed {
      logic auto_rst;
      logic run;
   } ctrl_t;

   localparam int unsigned CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/ctp_wr_decode.sv
module ctp_wr_decode
   import ctp_pkg::*;
(
   input  logic       wr,
   input  logic [1:0] sel,
   output logic       wr_ctrl,
   output logic       wr_cmp,
   output logic       wr_cnt
);

   fld_e fld;

   always_comb begin
      fld     = fld_e'(sel);
      wr_ctrl = 1'b0;
      wr_cmp  = 1'b0;
      wr_cnt  = 1'b0;
      if (wr) begin
         unique case (fld)
            FLD_CTRL: wr_ctrl = 1'b1;
            FLD_CMP:  wr_cmp  = 1'b1;
            FLD_CNT:  wr_cnt  = 1'b1;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/ctp_chan.sv
module ctp_chan
   import ctp_pkg::*;
#(
   parameter int unsigned DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_cmp,
   input  logic              wr_cnt,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl_q,
   output logic [DATA_W-1:0] cmp_q,
   output logic [DATA_W-1:0] cnt_q,
   output logic              irq_q
);

   logic              hit;
   logic [DATA_W-1:0] cnt_inc;

   assign hit     = ctrl_q.run && (cnt_q == cmp_q);
   assign cnt_inc = cnt_q + {{(DATA_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cmp_q  <= '0;
         cnt_q  <= '0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= hit;

         if (wr_ctrl)
            ctrl_q <= ctrl_t'(wdata[CTRL_BITS-1:0]);
         else if (hit && !ctrl_q.auto_rst)
            ctrl_q.run <= 1'b0;

         if (wr_cmp)
            cmp_q <= wdata;

         if (wr_cnt)
            cnt_q <= wdata;
         else if (hit) begin
            if (ctrl_q.auto_rst)
               cnt_q <= '0;
         end else if (ctrl_q.run)
            cnt_q <= cnt_inc;
      end
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.run && !hit && !wr_cnt) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !wr_cnt) |=> $stable(cnt_q)); // R7

   AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ctrl_q.auto_rst && !wr_ctrl && !wr_cnt) |=> (!ctrl_q.run && $stable(cnt_q) && irq_q)); // R5

   AST_RESTART_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctrl_q.auto_rst && !wr_ctrl && !wr_cnt) |=> (cnt_q == '0 && ctrl_q.run && irq_q)); // R6

   AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt_q == $past(wdata))); // R9

endmodule

// File: rtl/ctp_rd_mux.sv
module ctp_rd_mux
   import ctp_pkg::*;
#(
   parameter int unsigned DATA_W = 32
)(
   input  logic [1:0]        sel,
   input  ctrl_t             ctrl_q,
   input  logic [DATA_W-1:0] cmp_q,
   input  logic [DATA_W-1:0] cnt_q,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned PAD_W = DATA_W - CTRL_BITS;

   always_comb begin
      unique case (fld_e'(sel))
         FLD_CTRL: rdata = {{PAD_W{1'b0}}, ctrl_q};
         FLD_CMP:  rdata = cmp_q;
         FLD_CNT:  rdata = cnt_q;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/cmp_timer_pair.sv
module cmp_timer_pair
   import ctp_pkg::*;
#(
   parameter int unsigned NUM_TIMERS = 2,
   parameter int unsigned DATA_W     = 32
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_TIMERS-1:0]            tmr_wr,
   input  logic [NUM_TIMERS-1:0][1:0]       tmr_sel,
   input  logic [NUM_TIMERS-1:0][DATA_W-1:0] tmr_wdata,
   output logic [NUM_TIMERS-1:0][DATA_W-1:0] tmr_rdata,
   output logic [NUM_TIMERS-1:0]            tmr_irq
);

   if (NUM_TIMERS < 1) begin : g_bad_count
      $error("cmp_timer_pair: NUM_TIMERS must be at least 1");
   end
   if (DATA_W < CTRL_BITS) begin : g_bad_width
      $error("cmp_timer_pair: DATA_W must hold the control bits");
   end

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
      logic              wr_ctrl, wr_cmp, wr_cnt;
      ctrl_t             ctrl_q;
      logic [DATA_W-1:0] cmp_q, cnt_q;

      ctp_wr_decode u_dec (
         .wr      (tmr_wr[t]),
         .sel     (tmr_sel[t]),
         .wr_ctrl (wr_ctrl),
         .wr_cmp  (wr_cmp),
         .wr_cnt  (wr_cnt)
      );

      ctp_chan #(.DATA_W(DATA_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_ctrl (wr_ctrl),
         .wr_cmp  (wr_cmp),
         .wr_cnt  (wr_cnt),
         .wdata   (tmr_wdata[t]),
         .ctrl_q  (ctrl_q),
         .cmp_q   (cmp_q),
         .cnt_q   (cnt_q),
         .irq_q   (tmr_irq[t])
      );

      ctp_rd_mux #(.DATA_W(DATA_W)) u_mux (
         .sel    (tmr_sel[t]),
         .ctrl_q (ctrl_q),
         .cmp_q  (cmp_q),
         .cnt_q  (cnt_q),
         .rdata  (tmr_rdata[t])
      );

      AST_NONE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
         (tmr_wr[t] && tmr_sel[t] == 2'd3) |=> ($stable(ctrl_q) && $stable(cmp_q))); // R3
   end

endmodule

// File: tb/cmp_timer_pair_tb.sv
module cmp_timer_pair_tb;

   localparam int NT = 2;
   localparam int DW = 32;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [NT-1:0]           tmr_wr = '0;
   logic [NT-1:0][1:0]      tmr_sel = '0;
   logic [NT-1:0][DW-1:0]   tmr_wdata = '0;
   logic [NT-1:0][DW-1:0]   tmr_rdata;
   logic [NT-1:0]           tmr_irq;

   int unsigned cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done = 0;

   int unsigned exp_q0[$];
   int unsigned exp_q1[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cmp_timer_pair #(.NUM_TIMERS(NT), .DATA_W(DW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tmr_wr    (tmr_wr),
      .tmr_sel   (tmr_sel),
      .tmr_wdata (tmr_wdata),
      .tmr_rdata (tmr_rdata),
      .tmr_irq   (tmr_irq)
   );

   task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // monitor: pops predicted pulse cycles and compares
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int t = 0; t < NT; t++) begin
            if (tmr_irq[t]) begin
               int unsigned e;
               int n;
               n = (t == 0) ? exp_q0.size() : exp_q1.size();
               checks++;
               if (n == 0) begin
                  fails++;
                  $display("FAIL R4 timer %0d: unexpected pulse at cycle %0d expected none", t, cyc);
               end else begin
                  e = (t == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
                  if (e != cyc) begin
                     fails++;
                     $display("FAIL R4 timer %0d: pulse at cycle %0d expected %0d", t, cyc, e);
                  end
               end
            end
         end
      end
   end

   // driver: called at a negedge, returns at the next negedge with edge index
   task automatic wr(int t, logic [1:0] s, logic [DW-1:0] d, output int unsigned edge_n);
      tmr_wr[t]    = 1'b1;
      tmr_sel[t]   = s;
      tmr_wdata[t] = d;
      @(posedge clk);
      #1 edge_n = cyc;
      @(negedge clk);
      tmr_wr[t] = 1'b0;
   endtask

   task automatic rd(int t, logic [1:0] s, output logic [DW-1:0] v);
      tmr_sel[t] = s;
      #1 v = tmr_rdata[t];
   endtask

   task automatic push(int t, int unsigned c);
      if (t == 0) exp_q0.push_back(c); else exp_q1.push_back(c);
   endtask

   task automatic wait_empty(int t);
      for (int i = 0; i < 2000; i++) begin
         if ((t == 0 ? exp_q0.size() : exp_q1.size()) == 0) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   initial begin
      int unsigned w;
      logic [DW-1:0] v, v2;

      repeat (3) @(negedge clk);
      // R8: reset state
      for (int t = 0; t < NT; t++) begin
         for (int s = 0; s < 4; s++) begin
            rd(t, 2'(s), v);
            check("R8 reset read", v, '0);
         end
         check("R8 irq low", {31'b0, tmr_irq[t]}, '0);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R3: select 3 write ignored
      wr(0, 2'd3, 32'hDEAD_BEEF, w);
      rd(0, 2'd3, v); check("R3 sel3 reads zero", v, '0);
      rd(0, 2'd0, v); check("R3 ctrl untouched", v, '0);
      rd(0, 2'd1, v); check("R3 cmp untouched", v, '0);
      rd(0, 2'd2, v); check("R3 cnt untouched", v, '0);

      // R1: upper control bits read zero (enable stays clear)
      wr(0, 2'd0, 32'hFFFF_FFFC, w);
      rd(0, 2'd0, v); check("R1 ctrl upper bits", v, '0);

      // R4/R5: one-shot from zero, compare 5
      wr(0, 2'd1, 32'd5, w);
      wr(0, 2'd0, 32'd1, w);
      push(0, w + 6);
      wait_empty(0);
      repeat (8) @(negedge clk);
      rd(0, 2'd0, v); check("R5 enable cleared", v, '0);
      rd(0, 2'd2, v); check("R5 counter holds compare", v, 32'd5);

      // R2/R9: running count and counter overwrite
      wr(0, 2'd1, 32'd100, w);
      wr(0, 2'd2, 32'd10, w);
      wr(0, 2'd0, 32'd1, w);
      repeat (5) @(negedge clk);
      rd(0, 2'd2, v); check("R2 count rises by one per clock", v, 32'd10 + (cyc - w));
      wr(0, 2'd2, 32'd50, w);
      rd(0, 2'd2, v); check("R9 write beats increment", v, 32'd50);
      push(0, w + 51);
      wait_empty(0);
      rd(0, 2'd2, v); check("R5 counter at compare", v, 32'd100);

      // R6/R10: auto-restart on timer 1, timer 0 idle
      wr(1, 2'd1, 32'd3, w);
      wr(1, 2'd2, 32'd1, w);
      wr(1, 2'd0, 32'd3, w);
      push(1, w + 3); push(1, w + 7); push(1, w + 11);
      rd(0, 2'd2, v); check("R10 timer0 counter unchanged", v, 32'd100);
      rd(1, 2'd0, v); check("R1 ctrl readback both bits", v, 32'd3);
      wait_empty(1);
      // R7: stop immediately (pulse 3 was at w+11, next hit edge w+15)
      wr(1, 2'd0, 32'd0, w);
      rd(1, 2'd2, v);
      repeat (6) @(negedge clk);
      rd(1, 2'd2, v2); check("R7 counter frozen after stop", v2, v);
      rd(0, 2'd0, v); check("R10 timer0 ctrl unchanged", v, '0);

      // R11: preload resume after one-shot
      wr(0, 2'd1, 32'd4, w);
      wr(0, 2'd2, 32'd2, w);
      wr(0, 2'd0, 32'd1, w);
      push(0, w + 3);
      wait_empty(0);
      // R11: counter already equals compare
      wr(1, 2'd1, 32'd7, w);
      wr(1, 2'd2, 32'd7, w);
      wr(1, 2'd0, 32'd1, w);
      push(1, w + 1);
      wait_empty(1);
      repeat (10) @(negedge clk);
      rd(1, 2'd2, v); check("R11 counter stays at compare", v, 32'd7);

      check("R4 no pending pulses t0", exp_q0.size(), 0);
      check("R4 no pending pulses t1", exp_q1.size(), 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

endmodule